// File: doc/BRIEF.md
# Marker-Bit Asynchronous Byte Transmitter

This block turns one byte into an asynchronous serial frame. The frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. A free-running divide-by-16 counter sets the bit timing. The counter advances once for each pulse on a baud tick input, and that tick comes from an overflow source outside the block. Each bit lasts for one full pass of the counter, which is sixteen ticks.

Writing a byte loads it into a 9-bit shift register. A 1 goes into the top position as an end marker, and a send request is latched. The frame does not start at the moment of the write. It starts at the next wrap of the counter, so every bit edge falls on a counter boundary.

The frame ends when the marker has moved down to sit just above the last data bit. At that point the block makes one final shift, lets the line return high, and sets a sticky done flag. The flag stays set until the done-clear input is pulsed.

Top module: `uart_marker_tx`

## Requirements
- R1: After reset, `txd` is 1, `done` is 0 and `busy` is 0.
- R2: The line carries 0 for the start bit, then data bits 0 through 7 in that order, then 1 for the stop and idle level. Each bit lasts one counter period.
- R3: The bit counter advances only on clock edges where `baud_tick` is 1. One bit time is 16 such ticks. With no ticks, `txd` holds its value.
- R4: After an accepted write, `txd` stays 1 until the first counter wrap that follows the write edge. That wrap drives the start bit. A write on the same edge as a wrap waits for the next wrap.
- R5: `done` rises at the tenth counter wrap after the write. On that same edge `txd` returns to 1 and `busy` falls.
- R6: Once set, `done` stays 1 until `done_clr` is sampled high. A new set takes priority over a clear on the same edge.
- R7: A write while `busy` is 1 is ignored. The frame in progress keeps its data, and no second frame follows it.
- R8: `busy` rises on the edge after an accepted write and stays 1 through the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idles high |
| done | output | 1 | Sticky frame-sent flag |
| busy | output | 1 | A request is pending or a frame is on the line |

## Verification
The assertions assume that `txd` can change only on a tick edge. They also assume that `done_clr` is the only way to lower a done flag that has been set. The bench keeps to these assumptions. It drives the tick continuously except in one test that deliberately pauses it. It raises the clear only after it has checked the flag, and it sends writes during a busy frame only to test that they are ignored.

// File: rtl/uart_marker_tx.sv
module uart_marker_tx #(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_clr,
  output logic              txd,
  output logic              done,
  output logic              busy
);
  localparam int CW = $clog2(DIV);
  localparam int SW = DATA_W + 1;

  logic [CW-1:0] cnt;
  logic [SW-1:0] sh;
  logic          req, send, dph;
  logic          roll, last;

  assign roll = baud_tick && (cnt == CW'(DIV - 1));
  assign last = (sh[SW-1:1] == {{(SW-2){1'b0}}, 1'b1});
  assign busy = req | send;
  assign txd  = ~send | (dph & sh[0]);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (baud_tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      req  <= 1'b0;
      send <= 1'b0;
      dph  <= 1'b0;
    end else if (wr_en && !busy) begin
      sh  <= {1'b1, wr_data};
      req <= 1'b1;
    end else if (roll) begin
      if (req) begin
        req  <= 1'b0;
        send <= 1'b1;
        dph  <= 1'b0;
      end else if (send) begin
        if (!dph) dph <= 1'b1;
        else begin
          sh <= {1'b0, sh[SW-1:1]};
          if (last) begin
            send <= 1'b0;
            dph  <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          done <= 1'b0;
    else if (roll && send && dph && last) done <= 1'b1;
    else if (done_clr)                   done <= 1'b0;
  end
endmodule

module uart_marker_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_en,
  input logic done_clr,
  input logic txd,
  input logic done,
  input logic busy
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));
  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en) |=> busy);
endmodule

bind uart_marker_tx uart_marker_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .done_clr(done_clr), .txd(txd), .done(done), .busy(busy)
);

// File: tb/sim_uart_marker_tx.sv
`timescale 1ns/1ps
module sim_uart_marker_tx;
  logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0, done_clr = 0;
  logic [7:0] wr_data = 0;
  logic txd, done, busy;
  int total = 0, bad = 0;
  int ntick = 0, nroll = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_marker_tx u0 (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .done_clr(done_clr),
    .txd(txd), .done(done), .busy(busy));

  always @(posedge clk) begin
    if (!rst_n) begin
      ntick <= 0; nroll <= 0;
    end else if (baud_tick) begin
      ntick <= ntick + 1;
      if (ntick % 16 == 15) nroll <= nroll + 1;
    end
  end

  localparam logic [7:0] VEC [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_roll();
    int r = nroll;
    while (nroll == r) @(negedge clk);
  endtask

  // mode 0 normal, 1 write during frame, 2 tick pause
  task automatic frame(input logic [7:0] d, input int mode);
    int r;
    logic early_low = 0;
    wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk("R8 busy after write", {7'b0, busy}, 8'h01);
    r = nroll;
    while (nroll == r) begin
      if (txd !== 1'b1) early_low = 1;
      @(negedge clk);
    end
    chk("R4 line high until wrap", {7'b0, early_low}, 8'h00);
    chk("R2 start bit", {7'b0, txd}, 8'h00);
    for (int k = 2; k <= 10; k++) begin
      wait_roll();
      if (k <= 9) begin
        chk("R2 data bit", {7'b0, txd}, {7'b0, d[k-2]});
        chk("R5 done low mid frame", {7'b0, done}, 8'h00);
        chk("R8 busy in frame", {7'b0, busy}, 8'h01);
      end else begin
        chk("R5 stop high at tenth wrap", {7'b0, txd}, 8'h01);
        chk("R5 done at tenth wrap", {7'b0, done}, 8'h01);
        chk("R5 busy falls", {7'b0, busy}, 8'h00);
      end
      if (mode == 1 && k == 3) begin
        wr_data = ~d; wr_en = 1; @(negedge clk); wr_en = 0;
        chk("R7 busy write keeps bit", {7'b0, txd}, {7'b0, d[1]});
      end
      if (mode == 2 && k == 4) begin
        baud_tick = 0;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (txd !== d[2]) early_low = 1;
        end
        chk("R3 hold without ticks", {7'b0, early_low}, 8'h00);
        baud_tick = 1;
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 txd reset", {7'b0, txd}, 8'h01);
    chk("R1 done reset", {7'b0, done}, 8'h00);
    chk("R1 busy reset", {7'b0, busy}, 8'h00);
    rst_n = 1; baud_tick = 1;

    for (int v = 0; v < 6; v++) begin
      frame(VEC[v], (v == 2) ? 1 : 0);
      repeat (20) @(negedge clk);
      chk("R6 done sticky", {7'b0, done}, 8'h01);
      if (v == 2) begin
        logic seen_low = 0;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (txd !== 1'b1 || busy !== 1'b0) seen_low = 1;
        end
        chk("R7 no second frame", {7'b0, seen_low}, 8'h00);
      end
      done_clr = 1; @(negedge clk); done_clr = 0;
      chk("R6 done cleared", {7'b0, done}, 8'h00);
    end

    frame(8'hC3, 2);
    done_clr = 1; @(negedge clk); done_clr = 0;

    while (ntick % 16 != 15) @(negedge clk);
    frame(8'h96, 0);
    chk("R4 write on wrap edge ok", {7'b0, done}, 8'h01);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule